// File: doc/BRIEF.md
# NAND Flash Command Responder

This block models the control side of a byte-wide NAND flash device as the host sees it over the asynchronous command interface. The host drives chip enable, command and address latch enables, write and read strobes, write protect and an 8-bit data bus. The block answers on the data bus with an output enable and drives a ready/busy line. The strobes are brought into the system clock domain, and each rising edge of a strobe is turned into a one-cycle event that the control state machine acts on. The memory array is not modelled. A one-cycle `op_start` input stands in for a program or erase operation and keeps the device busy for a fixed number of clock cycles.

The state machine has four states. `ST_IDLE` waits for a command. `ST_ID_ADDR` waits for the address byte that follows the identification command. `ST_ID_READ` returns the five-byte identification string, one byte per read cycle. `ST_STATUS` returns the status byte on every read. The transitions are as follows. A command write of FFh goes to `ST_IDLE` and starts the reset busy interval. A command write of 70h goes to `ST_STATUS`. A command write of 90h goes to `ST_ID_ADDR`. Any other command goes to `ST_IDLE`. While the device is busy, commands other than FFh and 70h are ignored. In `ST_ID_ADDR`, an address of 00h goes to `ST_ID_READ` and any other address goes to `ST_IDLE`. A read cycle in `ST_ID_READ` advances the byte index, and the index wraps after the fifth byte.

Top module: `nand_cmd_responder`

## Requirements
- R1: After `rst_n` is released, `rb` is 1 and `io_oe` is 0. A read cycle in the idle state leaves `io_oe` at 0.
- R2: A command write of 90h followed by an address write of 00h makes the following five read cycles return ECh, D3h, 51h, 95h and 58h, in that order.
- R3: Identification mode persists. The sixth read cycle returns ECh again, and further reads continue through the same sequence.
- R4: Any new command write leaves identification mode. For example, 70h switches the reads to the status byte.
- R5: After 90h, an address byte other than 00h returns the block to idle, and the next read cycle leaves `io_oe` at 0.
- R6: A command write of FFh drives `rb` low for `RST_CYCLES` clock cycles, and then `rb` returns high. It also returns the state machine to idle, so the next read leaves `io_oe` at 0.
- R7: A pulse on `op_start` while the device is ready drives `rb` low for `OP_CYCLES` cycles. A reset command written during that interval aborts the operation, and `rb` returns high after `RST_CYCLES`.
- R8: A reset command written while a reset interval is still running is accepted and restarts the interval from its full length.
- R9: After 70h, every read returns the status byte. Bit 7 is `wp_n`, bit 6 is 1 when the device is ready, and bits 5..0 are 0. The resulting values are C0h (ready, write protect high), 40h (ready, write protect low) and 80h (busy, write protect high).
- R10: While the device is busy, a 90h command is ignored. An address cycle then leaves status mode unchanged.
- R11: While `ce_n` is high, `io_oe` stays 0, writes are ignored, and read strobes do not advance the identification index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; data is taken on its rising edge |
| re_n | input | 1 | Read strobe; its rising edge ends a read cycle |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Command or address byte from the host |
| op_start | input | 1 | One-cycle pulse that starts a stand-in busy operation |
| rb | output | 1 | Ready (1) or busy (0) |
| io_out | output | 8 | Read data; 0 when not enabled |
| io_oe | output | 1 | Output enable for the data bus |

## Verification
The identification sequence is read in several patterns: a straight read of five bytes, runs past the fifth byte to show the wrap, and reads interleaved with strobes while chip enable is high. These patterns separate a correct index from one that wraps at the wrong count or advances on reads the device should not see. The reset command is tried from an idle device, during a stand-in operation and during a running reset. The `rb` level is sampled at points where an unaborted operation, or an interval that was not restarted, would give the opposite value. Status reads are taken with write protect high and low and with the device ready and busy, so that each status bit is exercised on its own.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ID_ADDR,
        ST_ID_READ,
        ST_STATUS
    } resp_state_t;

    localparam int          ID_LEN      = 5;
    localparam int          ID_IDX_W    = $clog2(ID_LEN);
    localparam logic [7:0]  CMD_READ_ID = 8'h90;
    localparam logic [7:0]  CMD_STATUS  = 8'h70;
    localparam logic [7:0]  CMD_RESET   = 8'hFF;
    localparam logic [7:0]  ADDR_ID     = 8'h00;

    function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'hEC;
            3'd1:    b = 8'hD3;
            3'd2:    b = 8'h51;
            3'd3:    b = 8'h95;
            default: b = 8'h58;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/strobe_rise_det.sv
module strobe_rise_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_n};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= CW'(CYCLES);
        end else if (clear) begin
            count_q <= '0;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign busy = (count_q != '0);

    assert_timer_counts_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0 && !load && !clear) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/nand_cmd_responder.sv
module nand_cmd_responder
    import nand_resp_pkg::*;
#(
    parameter int RST_CYCLES  = 40,
    parameter int OP_CYCLES   = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    input  logic       op_start,
    output logic       rb,
    output logic [7:0] io_out,
    output logic       io_oe
);
    resp_state_t         state_q, state_d;
    logic [ID_IDX_W-1:0] idx_q, idx_d;
    logic [7:0]          status_q;
    logic                we_rise, re_rise;
    logic                cmd_wr, addr_wr, rd_done;
    logic                reset_cmd, rst_busy, op_busy, busy;

    strobe_rise_det #(.SYNC_STAGES(SYNC_STAGES)) u_we_det (
        .clk(clk), .rst_n(rst_n), .strobe_n(we_n), .rise(we_rise)
    );

    strobe_rise_det #(.SYNC_STAGES(SYNC_STAGES)) u_re_det (
        .clk(clk), .rst_n(rst_n), .strobe_n(re_n), .rise(re_rise)
    );

    assign cmd_wr    = we_rise & ~ce_n & cle & ~ale;
    assign addr_wr   = we_rise & ~ce_n & ale & ~cle;
    assign rd_done   = re_rise & ~ce_n;
    assign reset_cmd = cmd_wr & (io_in == CMD_RESET);

    busy_timer #(.CYCLES(RST_CYCLES)) u_rst_timer (
        .clk(clk), .rst_n(rst_n), .load(reset_cmd), .clear(1'b0), .busy(rst_busy)
    );

    busy_timer #(.CYCLES(OP_CYCLES)) u_op_timer (
        .clk(clk), .rst_n(rst_n), .load(op_start & ~busy & ~reset_cmd),
        .clear(reset_cmd), .busy(op_busy)
    );

    assign busy = rst_busy | op_busy;
    assign rb   = ~busy;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            status_q <= 8'h00;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            status_q <= {wp_n, ~busy, 6'b000000};
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (cmd_wr) begin
            if (io_in == CMD_RESET) begin
                state_d = ST_IDLE;
            end else if (io_in == CMD_STATUS) begin
                state_d = ST_STATUS;
            end else if (!busy) begin
                state_d = (io_in == CMD_READ_ID) ? ST_ID_ADDR : ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ID_ADDR: begin
                    if (addr_wr) begin
                        state_d = (io_in == ADDR_ID) ? ST_ID_READ : ST_IDLE;
                        idx_d   = '0;
                    end
                end
                ST_ID_READ: begin
                    if (rd_done) begin
                        idx_d = (idx_q == ID_IDX_W'(ID_LEN - 1)) ? '0 : idx_q + 1'b1;
                    end
                end
                ST_STATUS: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        io_oe  = 1'b0;
        io_out = 8'h00;
        if (!ce_n && !re_n) begin
            unique case (state_q)
                ST_ID_READ: begin
                    io_oe  = 1'b1;
                    io_out = id_byte(idx_q);
                end
                ST_STATUS: begin
                    io_oe  = 1'b1;
                    io_out = status_q;
                end
                default: ;
            endcase
        end
    end

    assert_oe_needs_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> (!ce_n && !re_n));

    assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < ID_IDX_W'(ID_LEN));

    assert_cmd_leaves_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && state_q == ST_ID_READ) |=> (state_q != ST_ID_READ));

    assert_reset_goes_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> !rb);

    assert_reset_aborts_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> !op_busy);

endmodule

// File: tb/sim_nand_cmd_responder.sv
module sim_nand_cmd_responder;
    localparam int RST_CYC = 40;
    localparam int OP_CYC  = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic       wp_n = 1'b1, op_start = 1'b0;
    logic [7:0] io_in = 8'h00;
    logic       rb, io_oe;
    logic [7:0] io_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] id_ref[$];

    always #2.5 clk = ~clk;

    nand_cmd_responder #(.RST_CYCLES(RST_CYC), .OP_CYCLES(OP_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
        .op_start(op_start), .rb(rb), .io_out(io_out), .io_oe(io_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] d, input logic ce = 1'b0);
        @(negedge clk);
        ce_n = ce; cle = c; ale = a; io_in = d; we_n = 1'b0;
        idle(3);
        we_n = 1'b1;
        idle(6);
        cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic rd(output logic oe, output logic [7:0] d, input logic ce = 1'b0);
        @(negedge clk);
        ce_n = ce; re_n = 1'b0;
        idle(3);
        oe = io_oe; d = io_out;
        re_n = 1'b1;
        idle(6);
        ce_n = 1'b0;
    endtask

    // reference of the identification ring: pop front on each seen read, push back
    task automatic rd_id(input string req);
        logic oe; logic [7:0] d; logic [7:0] e;
        rd(oe, d);
        e = id_ref.pop_front();
        id_ref.push_back(e);
        check(req, {7'd0, oe}, 8'd1);
        check(req, d, e);
    endtask

    task automatic enter_id();
        id_ref = '{8'hEC, 8'hD3, 8'h51, 8'h95, 8'h58};
        wr(1, 0, 8'h90);
        wr(0, 1, 8'h00);
    endtask

    initial begin
        fork
            begin
                logic oe; logic [7:0] d;
                idle(3);
                rst_n = 1'b1;
                idle(2);
                ce_n = 1'b0;
                // R1 reset state
                check("R1", {7'd0, rb}, 8'd1);
                check("R1", {7'd0, io_oe}, 8'd0);
                rd(oe, d);
                check("R1", {7'd0, oe}, 8'd0);

                // R2 identification sequence
                enter_id();
                for (int i = 0; i < 5; i++) rd_id("R2");
                // R3 wrap and persistence
                for (int i = 0; i < 3; i++) rd_id("R3");

                // R4 new command leaves id mode; R9 status ready, wp high
                wr(1, 0, 8'h70);
                rd(oe, d);
                check("R4", {7'd0, oe}, 8'd1);
                check("R9", d, 8'hC0);

                // R5 wrong address
                wr(1, 0, 8'h90);
                wr(0, 1, 8'h01);
                rd(oe, d);
                check("R5", {7'd0, oe}, 8'd0);

                // R11 chip enable high
                enter_id();
                rd_id("R11");
                rd(oe, d, 1'b1);
                check("R11", {7'd0, oe}, 8'd0);
                rd_id("R11");
                wr(1, 0, 8'h70, 1'b1);
                rd_id("R11");

                // R6 reset interval and return to idle
                wr(1, 0, 8'hFF);
                check("R6", {7'd0, rb}, 8'd0);
                idle(RST_CYC - 10);
                check("R6", {7'd0, rb}, 8'd0);
                idle(15);
                check("R6", {7'd0, rb}, 8'd1);
                rd(oe, d);
                check("R6", {7'd0, oe}, 8'd0);

                // R9 write protect low
                wp_n = 1'b0;
                wr(1, 0, 8'hFF);
                idle(RST_CYC + 5);
                wr(1, 0, 8'h70);
                rd(oe, d);
                check("R9", d, 8'h40);
                wp_n = 1'b1;
                idle(3);

                // R7 operation busy, R9 busy status, R10 ignored id command
                @(negedge clk); op_start = 1'b1;
                @(negedge clk); op_start = 1'b0;
                idle(10);
                check("R7", {7'd0, rb}, 8'd0);
                wr(1, 0, 8'h70);
                rd(oe, d);
                check("R9", d, 8'h80);
                wr(1, 0, 8'h90);
                wr(0, 1, 8'h00);
                rd(oe, d);
                check("R10", {7'd0, oe}, 8'd1);
                check("R10", d, 8'h80);
                wr(1, 0, 8'hFF);
                check("R7", {7'd0, rb}, 8'd0);
                idle(RST_CYC + 5);
                check("R7", {7'd0, rb}, 8'd1);
                wr(1, 0, 8'h70);
                rd(oe, d);
                check("R7", d, 8'hC0);

                // R8 reset during reset restarts
                wr(1, 0, 8'hFF);
                idle(25);
                wr(1, 0, 8'hFF);
                idle(20);
                check("R8", {7'd0, rb}, 8'd0);
                idle(25);
                check("R8", {7'd0, rb}, 8'd1);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule